// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and a byte-wide asynchronous static RAM with an 18-bit address. The host issues one read or write at a time through a request strobe. The controller then produces the memory's chip-select, output-enable and write-strobe waveforms. Each phase is held for a whole number of clock cycles. These counts are computed when the design is elaborated, from the clock period and from the nanosecond limits of the selected speed grade.

The memory has two chip selects. One is active low and the other is active high, and the device is selected only while both are in their active state. The controller asserts both together for every access and releases both when it is idle. It also owns the direction of the shared data bus. It drives write data only while output enable is inactive. After every read it waits out the memory's output-disable time before any later cycle can begin.

Read data is registered at the capture point. A one-cycle done pulse marks the end of every access. Requests that arrive while an access is in progress are dropped.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is active and after its release, both chip selects are inactive (`sram_ce_n`=1, `sram_ce`=0), `sram_oe_n`=1, `sram_we_n`=1, `busy`=0 and `done`=0.
- R2: While no access is in progress, both chip selects, the output enable and the write strobe stay inactive.
- R3: In a read, the memory is selected with `sram_we_n`=1 and `sram_oe_n`=0 for exactly RD cycles at a stable address. RD is ceil(max(access time, read cycle time, output-enable access)/period), which is 17 at 5 ns for the fast grade. `rdata` then holds the byte stored at that address.
- R4: In a write, `sram_we_n` is low for exactly WP cycles while the chip is selected and `sram_oe_n`=1. The address and data stay stable throughout, and the memory then holds the written byte. WP is ceil(max(pulse width, address-to-end, data-to-end, cycle time minus recovery)/period), which is 16 for the fast grade.
- R5: After `sram_we_n` rises, the address, the data and both chip selects are held for WR = ceil(write recovery/period) cycles, with a minimum of 1. WR is 1 for the fast grade.
- R6: After `sram_oe_n` rises at the end of a read, no write strobe begins within OHZ = ceil(output-disable time/period) cycles. OHZ is 5 for the fast grade.
- R7: The controller never drives `sram_dq` while `sram_oe_n` is low, so read data arrives at the port undisturbed.
- R8: A request that arrives while `busy` is high is ignored: it neither changes the memory nor delays the access in progress.
- R9: `done` is high for exactly one cycle per access. It first shows RD+OHZ cycles after a read is accepted and WP+WR cycles after a write is accepted, and `busy` drops in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, sampled when not busy |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| done | output | 1 | One-cycle end-of-access pulse |
| busy | output | 1 | Access in progress |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Active-low chip select |
| sram_ce | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_dq | inout | 8 | Bidirectional data bus |

## Verification
The bench places a write directly after a read, which is where the turnaround matters. A controller that skipped the output-disable wait would lower the write strobe fewer than OHZ cycles after the output enable rose. The bench also fires requests into busy cycles. A design that accepted them would corrupt a location that is read back later, or would change the done latency. Strobe widths and done latency are counted cycle by cycle, so an off-by-one in the ceiling conversion shows up as a wrong count. A read that captured data too early or with the bus contended returns the wrong byte.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int CLK_PERIOD_NS = 5,
  parameter bit FAST_GRADE    = 1'b1,
  parameter int AW            = 18,
  parameter int DW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          busy,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_ce,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  inout  wire  [DW-1:0] sram_dq
);

  function automatic int ns2cyc(input int ns);
    return (ns <= 0) ? 1 : (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_ACC  = FAST_GRADE ? 85 : 100;
  localparam int T_CYC  = FAST_GRADE ? 85 : 100;
  localparam int T_OEA  = FAST_GRADE ? 45 : 50;
  localparam int T_WP   = FAST_GRADE ? 60 : 70;
  localparam int T_AW   = FAST_GRADE ? 65 : 70;
  localparam int T_DW   = FAST_GRADE ? 35 : 45;
  localparam int T_WREC = 5;
  localparam int T_OFF  = FAST_GRADE ? 25 : 35;

  localparam int RD_CYC  = ns2cyc(max2(max2(T_ACC, T_CYC), T_OEA));
  localparam int WP_CYC  = ns2cyc(max2(max2(T_WP, T_AW), max2(T_DW, T_CYC - T_WREC)));
  localparam int WR_CYC  = ns2cyc(T_WREC);
  localparam int OHZ_CYC = ns2cyc(T_OFF);
  localparam int CW      = $clog2(RD_CYC + WP_CYC + OHZ_CYC + 2);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WR, S_WREC} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] wd_q;
  logic          drv;

  assign sram_dq = drv ? wd_q : {DW{1'bz}};
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      wd_q      <= '0;
      drv       <= 1'b0;
      rdata     <= '0;
      done      <= 1'b0;
      sram_addr <= '0;
      sram_ce_n <= 1'b1;
      sram_ce   <= 1'b0;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b1;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (req) begin
          sram_addr <= addr;
          wd_q      <= wdata;
          sram_ce_n <= 1'b0;
          sram_ce   <= 1'b1;
          if (we) begin
            st        <= S_WR;
            sram_we_n <= 1'b0;
            drv       <= 1'b1;
            cnt       <= CW'(WP_CYC - 1);
          end else begin
            st        <= S_RD;
            sram_oe_n <= 1'b0;
            cnt       <= CW'(RD_CYC - 1);
          end
        end
        S_RD: if (cnt == 0) begin
          rdata     <= sram_dq;
          sram_oe_n <= 1'b1;
          sram_ce_n <= 1'b1;
          sram_ce   <= 1'b0;
          st        <= S_TURN;
          cnt       <= CW'(OHZ_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt == 0) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        S_WR: if (cnt == 0) begin
          sram_we_n <= 1'b1;
          st        <= S_WREC;
          cnt       <= CW'(WR_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_WREC: if (cnt == 0) begin
          sram_ce_n <= 1'b1;
          sram_ce   <= 1'b0;
          drv       <= 1'b0;
          st        <= S_IDLE;
          done      <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] oe_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_hi_cnt <= CW'(OHZ_CYC);
    else if (!sram_oe_n) oe_hi_cnt <= '0;
    else if (oe_hi_cnt < CW'(OHZ_CYC)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
  end

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !drv);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !sram_ce_n && sram_ce && drv));

  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> (oe_hi_cnt >= CW'(OHZ_CYC)));

  // R5
  write_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> ($stable(sram_addr) && !sram_ce_n && sram_ce && drv));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sram_ce_n && !sram_ce && sram_oe_n && sram_we_n));

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  localparam int T = 5;

  function automatic int cyc(input int ns);
    return (ns <= 0) ? 1 : (ns + T - 1) / T;
  endfunction
  localparam int RD  = cyc(85);
  localparam int WP  = cyc(80);
  localparam int WR  = cyc(5);
  localparam int OHZ = cyc(25);

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [17:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic done, busy, sram_ce_n, sram_ce, sram_oe_n, sram_we_n;
  logic [17:0] sram_addr;
  wire  [7:0]  sram_dq;

  always #2.5 clk = ~clk;

  sram_async_ctrl dut (.clk, .rst_n, .req, .we, .addr, .wdata, .rdata, .done, .busy,
    .sram_addr, .sram_ce_n, .sram_ce, .sram_oe_n, .sram_we_n, .sram_dq);

  logic [7:0] mem [logic [17:0]];
  logic [7:0] shadow [logic [17:0]];

  function automatic logic [7:0] mem_rd(input logic [17:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] exp_rd(input logic [17:0] a);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction

  wire sel = !sram_ce_n && sram_ce;
  assign sram_dq = (sel && !sram_oe_n && sram_we_n) ? mem_rd(sram_addr) : 8'hzz;
  always @(posedge sram_we_n) if (sel) mem[sram_addr] = sram_dq;

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string r, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, expv);
    end
  endtask

  int oe_hi_run = 100;
  always @(negedge clk) if (rst_n) begin
    if (!sram_oe_n) oe_hi_run = 0; else oe_hi_run++;
  end

  task automatic do_op(input bit w, input logic [17:0] a, input logic [7:0] d,
                       input bit intrude);
    int k = 0, we_lo = 0, oe_lo = 0, rec = 0, gap = -1;
    bit ok_stable = 1, seen_we = 0, ok_rd = 1;
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    forever begin
      k++;
      if (intrude && k == 4) begin
        req = 1; we = 1; addr = a ^ 18'h1; wdata = ~d;
      end else req = 0;
      if (!sram_we_n) begin
        if (!seen_we) gap = oe_hi_run - 1;
        seen_we = 1; we_lo++;
        if (sram_addr != a || sram_dq != d) ok_stable = 0;
      end else if (seen_we && sel && !done) begin
        rec++;
        if (sram_addr != a) ok_stable = 0;
      end
      if (!sram_oe_n) begin
        oe_lo++;
        if (sram_addr != a || sram_dq != exp_rd(a) || !sram_we_n) ok_rd = 0;
      end
      if (done || k > 200) break;
      @(negedge clk);
    end
    req = 0;
    if (w) begin
      shadow[a] = d;
      // R4
      chk(we_lo == WP, "R4 strobe width", we_lo, WP);
      chk(ok_stable, "R4 addr/data stable", ok_stable, 1);
      chk(mem_rd(a) == d, "R4 memory content", mem_rd(a), d);
      // R5
      chk(rec == WR, "R5 recovery hold", rec, WR);
      // R6
      if (gap >= 0 && gap < 50) chk(gap >= OHZ, "R6 turnaround", gap, OHZ);
      // R9
      chk(k == WP + WR + 1, "R9 write latency", k, WP + WR + 1);
    end else begin
      // R3
      chk(oe_lo == RD, "R3 output-enable width", oe_lo, RD);
      chk(rdata == exp_rd(a), "R3 read data", rdata, exp_rd(a));
      // R7
      chk(ok_rd, "R7 bus undisturbed during read", ok_rd, 1);
      chk(k == RD + OHZ + 1, "R9 read latency", k, RD + OHZ + 1);
    end
    // R9
    chk(!busy, "R9 busy drops with done", busy, 0);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    // R2
    chk(sram_ce_n && !sram_ce && sram_oe_n && sram_we_n, "R2 idle deselect",
        {sram_ce_n, sram_ce, sram_oe_n, sram_we_n}, 4'b1011);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    // R1
    chk(sram_ce_n && !sram_ce && sram_oe_n && sram_we_n && !busy && !done,
        "R1 reset state", {sram_ce_n, sram_ce, sram_oe_n, sram_we_n, busy, done}, 6'b101100);
    rst_n = 1;
    @(negedge clk);
    chk(sram_ce_n && !sram_ce && !busy, "R1 after release", {sram_ce_n, sram_ce, busy}, 3'b100);

    do_op(1, 18'h00000, 8'hA5, 0);
    do_op(1, 18'h3FFFF, 8'h5A, 0);
    do_op(0, 18'h00000, 8'h00, 0);
    do_op(1, 18'h12345, 8'hFF, 0);
    do_op(0, 18'h3FFFF, 8'h00, 0);
    do_op(1, 18'h00100, 8'h3C, 0);
    // R8 intruding write during a read must not touch addr^1
    do_op(0, 18'h00100, 8'h00, 1);
    do_op(0, 18'h00101, 8'h00, 0);
    // R8 intruding write during a write
    do_op(1, 18'h00200, 8'h77, 1);
    do_op(0, 18'h00201, 8'h00, 0);
    do_op(0, 18'h00200, 8'h00, 0);

    for (int i = 0; i < 60; i++) begin
      logic [17:0] a;
      a = {8'h0, 10'($urandom_range(0, 63))};
      do_op(1'($urandom_range(0, 1)), a, 8'($urandom), 1'($urandom_range(0, 3) == 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule